// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block places a small two-bit-per-pixel cursor picture on top of a stream of display pixels. A raster generator presents each visible pixel together with its X/Y coordinate, measured from (0,0) at the top-left visible pixel. When that coordinate falls inside the cursor rectangle, the block replaces the frame-buffer pixel with a cursor pixel chosen by the stored code. Every other pixel passes through untouched, one clock later.

Software programs the block through a small register port and a 256-word image port. The register port sets the enable, the size, the update mode, the cursor position and two cursor colours. The image memory holds packed 2-bit codes in 32-bit words. In the smaller size, each cursor line uses two words. In the larger size, each line uses four words.

When the bottom-right cursor pixel leaves the block, a single-cycle interrupt fires. Software can take that as the point from which rewriting the image cannot tear the current frame. An optional frame-synchronised mode holds back position changes until the next frame-start strobe, so the cursor never jumps mid-frame.

Top module: `cursor_overlay`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `pix_valid_o` and `irq_o` are 0. After reset the cursor is disabled, so pixels pass through unchanged.
- R2: `pix_valid_o` and `pix_o` follow the input pixel with a latency of exactly one clock.
- R3: While the enable (register 0 bit 0) is 0, or the coordinate lies outside the cursor rectangle, `pix_o` equals the input pixel.
- R4: Register 0 bit 1 selects the size: 0 gives 32x32 and 1 gives 64x64. The rectangle covers X from posX to posX+size-1 and Y from posY to posY+size-1, both bounds included.
- R5: Inside the rectangle the 2-bit code chooses the output. Code 00 gives colour 0 (register 2), 01 gives colour 1 (register 3), 10 gives the frame-buffer pixel, and 11 gives its bitwise inverse.
- R6: The image word for a cursor pixel at offset (dx,dy) is dy*(size/16)+dx/16. Inside that word, the pixel with dx%16==0 sits in bits 31:30, and each step to the right moves two bits toward the LSB.
- R7: `irq_o` is high for one cycle, aligned with the output pixel that is the cursor's bottom-right pixel (dx=dy=size-1). It fires only when that input was valid and the cursor was enabled.
- R8: When register 0 bit 2 is 1, a write to the position register (register 1: X in bits 9:0, Y in bits 25:16) changes the displayed position only from the next `frame_start` onward.
- R9: When register 0 bit 2 is 0, a position write applies to the pixel presented in the very next cycle.
- R10: A rectangle that runs past the right or bottom screen edge shows its on-screen part correctly. If its bottom-right pixel is never scanned, no interrupt fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Strobe before the first pixel of a frame |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_x_i | input | XW | Raster X coordinate |
| pix_y_i | input | YW | Raster Y coordinate |
| pix_i | input | PIX_W | Frame-buffer pixel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 position, 2 colour 0, 3 colour 1 |
| reg_wdata | input | 32 | Register write data |
| img_we | input | 1 | Image memory write strobe |
| img_addr | input | 8 | Image word address |
| img_wdata | input | 32 | Image word data |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_o | output | PIX_W | Overlaid pixel |
| irq_o | output | 1 | Last-cursor-pixel pulse |

## Verification
The interrupt assertions rely on the raster never presenting the same coordinate on two back-to-back valid cycles. If it did, the bottom-right pixel could legitimately repeat. The stimulus scans each frame once, in strict raster order, and inserts only random invalid gaps between pixels. The bench never pulses `frame_start` in the same cycle as a position write, so the assertions never need to resolve that collision. Image and register writes either happen during idle cycles or sit beside a pixel whose expected value the bench takes from the state before the write.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int PIX_W = 24,
  parameter int XW    = 10,
  parameter int YW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             pix_valid_i,
  input  logic [XW-1:0]    pix_x_i,
  input  logic [YW-1:0]    pix_y_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             img_we,
  input  logic [7:0]       img_addr,
  input  logic [31:0]      img_wdata,
  output logic             pix_valid_o,
  output logic [PIX_W-1:0] pix_o,
  output logic             irq_o
);
  localparam int IMG_WORDS = 256;

  logic             ctl_en, ctl_big, ctl_fs;
  logic [XW-1:0]    pend_x, act_x;
  logic [YW-1:0]    pend_y, act_y;
  logic [PIX_W-1:0] col0, col1;
  logic [31:0]      img [IMG_WORDS];

  wire pos_wr = reg_we && reg_addr == 2'd1;
  wire unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en <= 1'b0; ctl_big <= 1'b0; ctl_fs <= 1'b0;
      pend_x <= '0; pend_y <= '0; act_x <= '0; act_y <= '0;
      col0 <= '0; col1 <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          2'd0: begin ctl_en <= reg_wdata[0]; ctl_big <= reg_wdata[1]; ctl_fs <= reg_wdata[2]; end
          2'd1: begin pend_x <= reg_wdata[XW-1:0]; pend_y <= reg_wdata[16 +: YW]; end
          2'd2: col0 <= reg_wdata[PIX_W-1:0];
          default: col1 <= reg_wdata[PIX_W-1:0];
        endcase
      end
      if (pos_wr && !ctl_fs) begin
        act_x <= reg_wdata[XW-1:0];
        act_y <= reg_wdata[16 +: YW];
      end else if (frame_start) begin
        act_x <= pend_x;
        act_y <= pend_y;
      end
    end
  end

  always_ff @(posedge clk)
    if (img_we) img[img_addr] <= img_wdata;

  wire [XW-1:0] sz_x = ctl_big ? XW'(64) : XW'(32);
  wire [YW-1:0] sz_y = ctl_big ? YW'(64) : YW'(32);
  wire [XW:0]   dx = {1'b0, pix_x_i} - {1'b0, act_x};
  wire [YW:0]   dy = {1'b0, pix_y_i} - {1'b0, act_y};
  wire hit = !dx[XW] && !dy[YW] && dx[XW-1:0] < sz_x && dy[YW-1:0] < sz_y;
  wire last = hit && dx[XW-1:0] == sz_x - 1'b1 && dy[YW-1:0] == sz_y - 1'b1;

  wire [7:0]  word_a = ctl_big ? {dy[5:0], dx[5:4]} : {2'b00, dy[4:0], dx[4]};
  wire [31:0] word   = img[word_a];
  wire [31:0] word_sh = word >> {~dx[3:0], 1'b0};

  logic [PIX_W-1:0] cur_pix;
  always_comb begin
    case (word_sh[1:0])
      2'b00:   cur_pix = col0;
      2'b01:   cur_pix = col1;
      2'b10:   cur_pix = pix_i;
      default: cur_pix = ~pix_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid_o <= 1'b0;
      irq_o       <= 1'b0;
      pix_o       <= '0;
    end else begin
      pix_valid_o <= pix_valid_i;
      irq_o       <= pix_valid_i && ctl_en && last;
      pix_o       <= (ctl_en && hit) ? cur_pix : pix_i;
    end
  end

  p_valid_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_i |=> pix_valid_o);
  p_valid_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid_i |=> !pix_valid_o);
  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_i && !ctl_en) |=> pix_o == $past(pix_i));
  p_irq_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> pix_valid_o);
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> !irq_o);
  p_fsync_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_fs && !frame_start) |=> ($stable(act_x) && $stable(act_y)));
  p_immediate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_wr && !ctl_fs) |=> act_x == $past(reg_wdata[XW-1:0]));
endmodule

// File: tb/cursor_overlay_tb.sv
`timescale 1ns/1ps
module cursor_overlay_tb;
  localparam int W = 96;
  localparam int H = 72;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0, pix_valid_i = 1'b0;
  logic [9:0]  pix_x_i = '0, pix_y_i = '0;
  logic [23:0] pix_i = '0;
  logic        reg_we = 1'b0, img_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, img_wdata = '0;
  logic [7:0]  img_addr = '0;
  logic        pix_valid_o, irq_o;
  logic [23:0] pix_o;

  cursor_overlay u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .pix_valid_i(pix_valid_i), .pix_x_i(pix_x_i), .pix_y_i(pix_y_i), .pix_i(pix_i),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .img_we(img_we), .img_addr(img_addr), .img_wdata(img_wdata),
    .pix_valid_o(pix_valid_o), .pix_o(pix_o), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // staged stimulus
  logic        s_fs = 0, s_v = 0, s_rwe = 0, s_iwe = 0;
  int          s_x = 0, s_y = 0;
  logic [23:0] s_p = '0;
  logic [1:0]  s_ra = '0;
  logic [31:0] s_rd = '0, s_id = '0;
  logic [7:0]  s_ia = '0;
  string       in_tag = "R5", out_tag = "R1";

  // reference model state
  logic        m_en = 0, m_big = 0, m_fs = 0;
  int          m_px = 0, m_py = 0, m_ax = 0, m_ay = 0;
  logic [23:0] m_c0 = '0, m_c1 = '0;
  logic [31:0] m_img [256];
  int          exp_irqs = 0;

  logic        qv[$], qi[$];
  logic [23:0] qp[$];
  string       qt[$];

  task automatic step();
    int sz, dx, dy, c;
    logic ins, irq, fs_old;
    logic [23:0] e;
    logic [31:0] w;
    @(negedge clk);
    frame_start = s_fs; pix_valid_i = s_v; pix_x_i = s_x[9:0]; pix_y_i = s_y[9:0]; pix_i = s_p;
    reg_we = s_rwe; reg_addr = s_ra; reg_wdata = s_rd;
    img_we = s_iwe; img_addr = s_ia; img_wdata = s_id;
    sz = m_big ? 64 : 32;
    dx = s_x - m_ax; dy = s_y - m_ay;
    ins = m_en && dx >= 0 && dx < sz && dy >= 0 && dy < sz;
    e = s_p; irq = 1'b0;
    if (ins) begin
      w = m_img[dy * (sz / 16) + dx / 16];
      c = int'((w >> (30 - 2 * (dx % 16))) & 32'd3);
      case (c)
        0: e = m_c0;
        1: e = m_c1;
        2: e = s_p;
        default: e = ~s_p;
      endcase
      irq = s_v && dx == sz - 1 && dy == sz - 1;
    end
    if (irq) exp_irqs++;
    qv.push_back(s_v); qp.push_back(e); qi.push_back(irq);
    qt.push_back(ins ? in_tag : out_tag);
    fs_old = m_fs;
    if (s_fs && !(s_rwe && s_ra == 2'd1 && !fs_old)) begin m_ax = m_px; m_ay = m_py; end
    if (s_rwe) begin
      case (s_ra)
        2'd0: begin m_en = s_rd[0]; m_big = s_rd[1]; m_fs = s_rd[2]; end
        2'd1: begin
          m_px = int'(s_rd[9:0]); m_py = int'(s_rd[25:16]);
          if (!fs_old) begin m_ax = m_px; m_ay = m_py; end
        end
        2'd2: m_c0 = s_rd[23:0];
        default: m_c1 = s_rd[23:0];
      endcase
    end
    if (s_iwe) m_img[s_ia] = s_id;
    s_fs = 0; s_v = 0; s_rwe = 0; s_iwe = 0;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    s_rwe = 1; s_ra = a; s_rd = d; step();
  endtask

  function automatic logic [31:0] pos(input int x, input int y);
    return {6'd0, 10'(y), 6'd0, 10'(x)};
  endfunction

  task automatic run_frame(input int wr_at, input int nx, input int ny);
    s_fs = 1; step();
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        if ($urandom % 8 == 0) step();
        s_v = 1; s_x = x; s_y = y; s_p = 24'($urandom);
        if (y * W + x == wr_at) begin s_rwe = 1; s_ra = 2'd1; s_rd = pos(nx, ny); end
        step();
      end
  endtask

  // scoreboard monitor
  initial forever begin
    logic ev, ei; logic [23:0] ep; string et;
    @(posedge clk); #2;
    if (qv.size() > 0) begin
      ev = qv.pop_front(); ep = qp.pop_front(); ei = qi.pop_front(); et = qt.pop_front();
      n_chk++;
      if (pix_valid_o !== ev) begin
        n_fail++; $display("FAIL R2 valid: got %b exp %b", pix_valid_o, ev);
      end else if (ev && pix_o !== ep) begin
        n_fail++; $display("FAIL %s pixel: got %h exp %h", et, pix_o, ep);
      end
      if (irq_o !== ei) begin
        n_fail++; $display("FAIL R7 irq: got %b exp %b", irq_o, ei);
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got hang exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    n_chk++;
    if (pix_valid_o !== 1'b0 || irq_o !== 1'b0) begin
      n_fail++; $display("FAIL R1 reset outputs: got %b%b exp 00", pix_valid_o, irq_o);
    end
    rst_n = 1'b1;
    // R1: disabled after reset, pixels pass through
    for (int i = 0; i < 40; i++) begin
      s_v = 1; s_x = i; s_y = 0; s_p = 24'($urandom); step();
    end
    out_tag = "R3";
    for (int i = 0; i < 256; i++) begin
      s_iwe = 1; s_ia = 8'(i); s_id = $urandom; step();
    end
    wreg(2'd2, 32'h00A1B2C3);
    wreg(2'd3, 32'h005D6E7F);
    // R5 R6: small cursor, immediate mode
    in_tag = "R5";
    wreg(2'd0, 32'd1); wreg(2'd1, pos(10, 5));
    exp_irqs = 0; run_frame(-1, 0, 0);
    n_chk++; if (exp_irqs != 1) begin n_fail++; $display("FAIL R7 irq count: got %0d exp 1", exp_irqs); end
    // R6: large cursor, four words per line
    in_tag = "R6";
    wreg(2'd0, 32'd3); wreg(2'd1, pos(20, 4));
    run_frame(-1, 0, 0);
    // R10: clipped at right and bottom, no interrupt
    in_tag = "R10";
    wreg(2'd1, pos(60, 40));
    exp_irqs = 0; run_frame(-1, 0, 0);
    n_chk++; if (exp_irqs != 0) begin n_fail++; $display("FAIL R10 irq count: got %0d exp 0", exp_irqs); end
    // R4: small cursor ending exactly on the last column and row
    in_tag = "R4";
    wreg(2'd0, 32'd1); wreg(2'd1, pos(W - 32, H - 32));
    exp_irqs = 0; run_frame(-1, 0, 0);
    n_chk++; if (exp_irqs != 1) begin n_fail++; $display("FAIL R4 irq count: got %0d exp 1", exp_irqs); end
    // R8: frame-synchronised updates
    in_tag = "R8";
    wreg(2'd0, 32'd5); wreg(2'd1, pos(5, 5));
    run_frame(W * 10 + 3, 50, 30);
    run_frame(-1, 0, 0);
    // R9: immediate update mid-frame
    in_tag = "R9";
    wreg(2'd0, 32'd3);
    run_frame(W * 30, 2, 2);
    // R3: disabled, full pass-through
    in_tag = "R3";
    wreg(2'd0, 32'd2);
    run_frame(-1, 0, 0);
    repeat (4) step();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule